// File: doc/BRIEF.md
# Transmit Queue with Threshold Empty Flag

This block is the transmit side queue of a serial port. It holds up to sixteen bytes that wait for the shifter. Two sources can load it: a processor bus port and a DMA write port. The shifter drains it through a valid/ready pair. The fill level is reported in the high byte of a 16-bit count word.

A sticky "transmit queue low" flag tells the host that it may refill the queue. The flag rises when a byte leaves for the shifter and the remaining fill is at or below a threshold picked by a 2-bit selector. It falls only in one of two ways. In the first, software reads the flag as 1, then writes 0 to it, and a later load carries the fill above the threshold. In the second, a DMA load carries the fill above the threshold, with no handshake. While the flag is set and its enable is on, a request line asks the interrupt controller or the DMA engine to refill the queue.

Top module: `uart_txq_flag`

## Requirements
- R1: Reset (asynchronous, active low) empties the queue (count 0, `shift_valid` 0) and sets `tx_empty` to 1.
- R2: Accepted bytes leave on `shift_data` in the order they were loaded. `shift_valid` is 1 whenever the queue is not empty, and a byte is removed on a clock edge that has `shift_valid` and `shift_rdy` both 1.
- R3: `fill_word[15:8]` holds the number of queued bytes and `fill_word[7:0]` is always zero. Each change becomes visible on the clock edge that causes it.
- R4: A load into a queue that holds 16 bytes is discarded. The count stays 16 and the stored bytes are unchanged.
- R5: `trig_sel` selects the threshold: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 0 bytes.
- R6: `tx_empty` becomes 1 on an edge that removes a byte and leaves a count at or below the threshold.
- R7: After `stat_rd` is seen while `tx_empty` is 1 and a later `stat_wr` with `stat_wval` 0, `tx_empty` falls on the first edge where a load leaves the count above the threshold.
- R8: A `stat_wr` with value 0 that has no prior read of 1 has no effect, and a `stat_wr` with value 1 never changes `tx_empty`. Processor loads do not clear the flag without the handshake.
- R9: A DMA load that leaves the count above the threshold clears `tx_empty` with no handshake.
- R10: `tx_req` is `tx_empty` gated by `irq_en`.
- R11: A load and a removal on the same edge leave the count unchanged, and the flag rules apply to that resulting count.
- R12: When `cpu_wr` and `dma_wr` are both 1, only the processor byte is loaded, and that load does not count as a DMA load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_sel | input | 2 | Threshold selector |
| irq_en | input | 1 | Request enable |
| cpu_wr | input | 1 | Processor byte load strobe |
| cpu_data | input | 8 | Processor byte |
| dma_wr | input | 1 | DMA byte load strobe |
| dma_data | input | 8 | DMA byte |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wval | input | 1 | Value written to the flag |
| shift_rdy | input | 1 | Shifter takes the head byte |
| shift_valid | output | 1 | Head byte present |
| shift_data | output | 8 | Head byte |
| fill_word | output | 16 | Count word, fill level in the high byte |
| tx_empty | output | 1 | Sticky threshold flag |
| tx_req | output | 1 | Interrupt/DMA request |

## Verification
A wrong pointer or count shows up when the next byte reaches `shift_data`, or on `fill_word` one edge after the faulty update. A lost or spurious arm or pending state in the clear handshake shows as `tx_empty` that stays high, or drops early, on the first load that crosses the threshold. The bench keeps a byte-order model and a flag model built from the requirements. It compares them at the ports after every edge, so each error is reported in the cycle it first appears.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    TRG_8 = 2'b00,
    TRG_4 = 2'b01,
    TRG_2 = 2'b10,
    TRG_0 = 2'b11
  } trig_sel_e;

  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRG_8:   return 8'd8;
      TRG_4:   return 8'd4;
      TRG_2:   return 8'd2;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/txq_src_arb.sv
module txq_src_arb #(
  parameter int DW = 8
) (
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_data,
  input  logic          dma_wr,
  input  logic [DW-1:0] dma_data,
  output logic          push_req,
  output logic          push_dma,
  output logic [DW-1:0] push_data
);
  always_comb begin
    push_req  = cpu_wr | dma_wr;
    push_dma  = dma_wr & ~cpu_wr;
    push_data = cpu_wr ? cpu_data : dma_data;
  end
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [DW-1:0] head
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0]         wr_en;
  logic [AW-1:0]            wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]            rd_ptr_q, rd_ptr_d;

  always_comb begin
    push_ok  = push_req && (cnt_q != CW'(DEPTH));
    pop_ok   = pop_req && (cnt_q != '0);
    wr_ptr_d = push_ok ? wr_ptr_q + AW'(1) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? rd_ptr_q + AW'(1) : rd_ptr_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_nxt = cnt_q + CW'(1);
      2'b01:   cnt_nxt = cnt_q - CW'(1);
      default: cnt_nxt = cnt_q;
    endcase
    for (int i = 0; i < DEPTH; i++) begin
      wr_en[i] = push_ok && (wr_ptr_q == AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) mem_q[i] <= push_data;
    end
  end

  assign head = mem_q[rd_ptr_q];
endmodule

// File: rtl/txq_flag.sv
module txq_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          push_dma,
  input  logic          pop_ok,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [7:0]    trig,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          stat_wval,
  output logic          flag_q
);
  logic flag_d, arm_q, arm_d, pend_q, pend_d;
  logic above, set_c, clr_c, wr_zero;

  always_comb begin
    above   = 8'(cnt_nxt) > trig;
    wr_zero = stat_wr && !stat_wval;
    set_c   = pop_ok && !above;
    clr_c   = push_ok && above && (pend_q || push_dma);

    flag_d = flag_q;
    if (clr_c)      flag_d = 1'b0;
    else if (set_c) flag_d = 1'b1;

    arm_d = arm_q;
    if (clr_c || wr_zero)      arm_d = 1'b0;
    else if (stat_rd && flag_q) arm_d = 1'b1;

    pend_d = pend_q;
    if (clr_c)                 pend_d = 1'b0;
    else if (wr_zero && arm_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/uart_txq_flag.sv
module uart_txq_flag #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_data,
  input  logic          dma_wr,
  input  logic [DW-1:0] dma_data,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          stat_wval,
  input  logic          shift_rdy,
  output logic          shift_valid,
  output logic [DW-1:0] shift_data,
  output logic [15:0]   fill_word,
  output logic          tx_empty,
  output logic          tx_req
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          push_req, push_dma, push_ok, pop_ok;
  logic [DW-1:0] push_data;
  logic [CW-1:0] cnt_q, cnt_nxt;

  txq_src_arb #(.DW(DW)) u_arb (
    .cpu_wr(cpu_wr), .cpu_data(cpu_data),
    .dma_wr(dma_wr), .dma_data(dma_data),
    .push_req(push_req), .push_dma(push_dma), .push_data(push_data)
  );

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_data(push_data), .pop_req(shift_rdy),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .head(shift_data)
  );

  txq_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst_n(rst_n),
    .push_ok(push_ok), .push_dma(push_dma), .pop_ok(pop_ok),
    .cnt_nxt(cnt_nxt), .trig(txq_pkg::trig_level(trig_sel)),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wval(stat_wval),
    .flag_q(tx_empty)
  );

  assign shift_valid = (cnt_q != '0);
  assign fill_word   = {8'(cnt_q), 8'h00};
  assign tx_req      = tx_empty & irq_en;
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  trig_sel,
  input logic        irq_en,
  input logic        cpu_wr,
  input logic        dma_wr,
  input logic        shift_rdy,
  input logic        shift_valid,
  input logic [15:0] fill_word,
  input logic        tx_empty,
  input logic        tx_req
);
  // R4
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_word[15:8] <= 8'(DEPTH));
  // R3
  cnt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_word[7:0] == 8'h00);
  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_word[15:8] == $past(fill_word[15:8])) ||
    (fill_word[15:8] == $past(fill_word[15:8]) + 8'd1) ||
    (fill_word[15:8] + 8'd1 == $past(fill_word[15:8])));
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(shift_rdy && shift_valid));
  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> ($past(cpu_wr || dma_wr) &&
      (fill_word[15:8] > txq_pkg::trig_level($past(trig_sel)))));
  // R10
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (irq_en && tx_empty));
endmodule

bind uart_txq_flag txq_chk #(.DEPTH(DEPTH)) u_txq_chk (
  .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .irq_en(irq_en),
  .cpu_wr(cpu_wr), .dma_wr(dma_wr), .shift_rdy(shift_rdy),
  .shift_valid(shift_valid), .fill_word(fill_word),
  .tx_empty(tx_empty), .tx_req(tx_req)
);

// File: tb/test_uart_txq_flag.sv
`timescale 1ns/1ps
module test_uart_txq_flag;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] trig_sel;
  logic irq_en, cpu_wr, dma_wr, stat_rd, stat_wr, stat_wval, shift_rdy;
  logic [7:0] cpu_data, dma_data, shift_data;
  logic shift_valid, tx_empty, tx_req;
  logic [15:0] fill_word;

  int checks = 0;
  int errors = 0;
  logic [7:0] q[$];

  always #2.5 clk = ~clk;

  uart_txq_flag i_uart_txq_flag (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .irq_en(irq_en),
    .cpu_wr(cpu_wr), .cpu_data(cpu_data), .dma_wr(dma_wr), .dma_data(dma_data),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wval(stat_wval),
    .shift_rdy(shift_rdy), .shift_valid(shift_valid), .shift_data(shift_data),
    .fill_word(fill_word), .tx_empty(tx_empty), .tx_req(tx_req)
  );

  // fields: [31]cpu [30]dma [29]rd [28]wr [27]wval [26]pop [23:16]data [12:8]cnt [0]flag
  function automatic logic [31:0] v(input logic c, input logic d, input logic r,
      input logic w, input logic wv, input logic p, input logic [7:0] dat,
      input logic [4:0] ec, input logic ef);
    return {c, d, r, w, wv, p, 2'b00, dat, 3'b000, ec, 7'd0, ef};
  endfunction

  // threshold 4 throughout the table
  localparam logic [31:0] VEC [27] = '{
    v(1,0,0,0,0,0,8'hA0,5'd1,1), v(1,0,0,0,0,0,8'hA1,5'd2,1),
    v(0,0,1,0,0,0,8'h00,5'd2,1), v(0,0,0,1,0,0,8'h00,5'd2,1),
    v(1,0,0,0,0,0,8'hA2,5'd3,1), v(1,0,0,0,0,0,8'hA3,5'd4,1),
    v(1,0,0,0,0,0,8'hA4,5'd5,0), v(0,0,0,0,0,1,8'h00,5'd4,1),
    v(1,0,0,0,0,0,8'hA5,5'd5,1), v(0,0,0,1,0,0,8'h00,5'd5,1),
    v(1,0,0,0,0,0,8'hA6,5'd6,1), v(0,0,1,0,0,0,8'h00,5'd6,1),
    v(0,0,0,1,1,0,8'h00,5'd6,1), v(1,0,0,0,0,0,8'hA7,5'd7,1),
    v(0,0,0,1,0,0,8'h00,5'd7,1), v(1,0,0,0,0,1,8'hA8,5'd7,0),
    v(0,0,0,0,0,1,8'h00,5'd6,0), v(0,0,0,0,0,1,8'h00,5'd5,0),
    v(0,0,0,0,0,1,8'h00,5'd4,1), v(0,1,0,0,0,0,8'hB0,5'd5,0),
    v(0,0,0,0,0,1,8'h00,5'd4,1), v(1,1,0,0,0,0,8'hC0,5'd5,1),
    v(0,0,0,0,0,1,8'h00,5'd4,1), v(0,0,0,0,0,1,8'h00,5'd3,1),
    v(0,0,0,0,0,1,8'h00,5'd2,1), v(0,0,0,0,0,1,8'h00,5'd1,1),
    v(0,0,0,0,0,1,8'h00,5'd0,1)
  };

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 0; dma_wr = 0; stat_rd = 0; stat_wr = 0; stat_wval = 0; shift_rdy = 0;
  endtask

  // one cycle at negedge; model tracks order and count (R2, R4)
  task automatic step(input logic c, input logic d, input logic r, input logic w,
      input logic wv, input logic p, input logic [7:0] dat);
    logic full;
    cpu_wr = c; dma_wr = d; stat_rd = r; stat_wr = w; stat_wval = wv; shift_rdy = p;
    cpu_data = dat; dma_data = ~dat;
    full = (q.size() == 16);
    if (p && q.size() > 0) begin
      chk("R2 head", shift_data, q[0]);
      void'(q.pop_front());
    end
    if ((c || d) && !full) q.push_back(c ? dat : ~dat);
    @(posedge clk);
    @(negedge clk);
    idle();
    chk("R3 low", fill_word[7:0], 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] e;
    int lvl;
    idle();
    cpu_data = 0; dma_data = 0; trig_sel = 2'b01; irq_en = 1; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 cnt", fill_word[15:8], 0);
    chk("R1 flag", tx_empty, 1);
    chk("R1 valid", shift_valid, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      e = VEC[i];
      step(e[31], e[30], e[29], e[28], e[27], e[26], e[23:16]);
      chk("R7 R8 R9 R11 R12 cnt", fill_word[15:8], e[12:8]);
      chk("R6 R7 R8 R9 flag", tx_empty, e[0]);
      chk("R10 req", tx_req, e[0]);
    end

    // R10 gate off and on
    irq_en = 0; #1;
    chk("R10 off", tx_req, 0);
    irq_en = 1; #1;
    chk("R10 on", tx_req, tx_empty);

    // R5 each threshold via DMA loads
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      lvl = (s == 0) ? 8 : (s == 1) ? 4 : (s == 2) ? 2 : 0;
      for (int k = 0; k < lvl; k++) step(0, 1, 0, 0, 0, 0, 8'(k));
      chk("R5 below", tx_empty, 1);
      step(0, 1, 0, 0, 0, 0, 8'h55);
      chk("R5 R9 above", tx_empty, 0);
      step(0, 0, 0, 0, 0, 1, 8'h00);
      chk("R5 R6 at", tx_empty, 1);
      for (int k = 0; k < lvl; k++) step(0, 0, 0, 0, 0, 1, 8'h00);
      chk("R2 drained", shift_valid, 0);
    end

    // R4 overflow
    trig_sel = 2'b11;
    for (int k = 0; k < 17; k++) step(1, 0, 0, 0, 0, 0, 8'(8'h10 + k));
    chk("R4 full cnt", fill_word[15:8], 16);
    step(1, 0, 0, 0, 0, 1, 8'hEE);
    chk("R4 full push+pop", fill_word[15:8], 15);
    for (int k = 0; k < 15; k++) step(0, 0, 0, 0, 0, 1, 8'h00);
    chk("R4 empty", shift_valid, 0);
    chk("R6 flag", tx_empty, 1);

    // R1 reset mid-run
    step(0, 1, 0, 0, 0, 0, 8'h01);
    chk("R9 pre", tx_empty, 0);
    rst_n = 0; #1;
    chk("R1 async cnt", fill_word[15:8], 0);
    chk("R1 async flag", tx_empty, 1);
    @(negedge clk); rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule